// File: doc/BRIEF.md
# Boot-Mode Test Access Port

This block is a boundary-scan style test access port. It has a sixteen-state controller driven by TMS, a three-bit instruction register and a one-bit bypass path. It also holds a three-bit programming-mode register that a host loads over the serial port. A host that selects this register can ask the boot logic to enter a loader session after the next reset, and can name the interface that session should use.

The register sits in the system clock domain, where the CPU can read it and write it. Updates from the serial side cross from TCK into the system clock through two-flop synchronisers. The enable bit and the gated source field drive the reset and boot logic directly. The register is cleared by power-on reset. It is also cleared while the controller sits in Test-Logic-Reset.

TCK is assumed to run at no more than a quarter of the system clock rate. This keeps every serial-side event visible in the system domain for at least three system cycles.

Top module: `prog_tap_top`

## Requirements
- R1: From any state, TMS held high for five rising TCK edges brings the controller to Test-Logic-Reset. All sixteen states follow the standard boundary-scan transition graph.
- R2: The instruction register is 3 bits wide. Capture-IR loads 3'b001, so the host shifts out 1, 0, 0 (LSB first). A newly shifted code becomes active only on the falling TCK edge in Update-IR.
- R3: The active instruction is kept across any number of data scans. It changes only when a new code is loaded or the controller enters Test-Logic-Reset, which selects code 3'b111 (bypass).
- R4: With code 3'b100 active, the data path is 3 bits long. Capture-DR loads the current register value. Shift-DR moves TDI into bit 2 and presents bit 0 on TDO. Update-DR writes the shifted value into the register.
- R5: Every code other than 3'b100 selects a 1-bit bypass path that captures 0. Data scans under these codes leave the register unchanged.
- R6: Bit 0 of the register drives boot_prog_en. Bits 2:1 drive boot_src while bit 0 is 1, where 2'b00 names the serial port and the other codes are reserved and passed through. boot_src is forced to 2'b00 while bit 0 is 0.
- R7: cpu_rd_data always shows the register. A cycle with cpu_wr_en high loads cpu_wr_data at the next system clock edge. With no write, no update and no reset, the register holds its value.
- R8: A serial update reaches the register through a two-flop synchroniser. If it lands in the same system cycle as a CPU write, the serial value is stored.
- R9: Power-on reset clears the register to 3'b000. So does Test-Logic-Reset, and this clear takes priority over both kinds of write.
- R10: tdo_en is high only while the controller is in Shift-IR or Shift-DR. TDO changes on the falling edge of TCK and is 0 while tdo_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Asynchronous active-low power-on reset for both domains |
| tck | input | 1 | Serial test clock |
| tms | input | 1 | Mode select sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shift data |
| sys_clk | input | 1 | System clock of the CPU-side register |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_data | input | 3 | CPU write value |
| cpu_rd_data | output | 3 | Current register value |
| boot_prog_en | output | 1 | Request for a loader session after reset |
| boot_src | output | 2 | Programming source, 00 when not requested |

## Verification
The bench writes all eight register values over the serial port and all eight through the CPU port, and reads each back by the opposite route. A swapped shift direction or a missing capture would return the wrong bits. Each of the seven non-programming codes is loaded, and the bench checks both the one-cycle delay and that the register is untouched. A decoder that let any of those codes through would change the register or lengthen the path. The bench holds a CPU write across a serial update, which catches a design that gives the CPU priority. Five TMS highs are then applied, and the bench checks both the cleared register and the return to bypass, which catches a design that clears only one of them.

// File: rtl/prog_tap_pkg.sv
`timescale 1ns/1ps
package prog_tap_pkg;
  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;
endpackage

// File: rtl/prog_tap_rst_sync.sv
`timescale 1ns/1ps
module prog_tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/prog_tap_sync.sv
`timescale 1ns/1ps
module prog_tap_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/prog_tap_fsm.sv
`timescale 1ns/1ps
module prog_tap_fsm
  import prog_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end
endmodule

// File: rtl/prog_tap_top.sv
`timescale 1ns/1ps
module prog_tap_top
  import prog_tap_pkg::*;
#(
  parameter int               IR_W        = 3,
  parameter int               PROG_W      = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [IR_W-1:0]  PROG_OP     = 3'b100
) (
  input  logic              por_n,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic              sys_clk,
  input  logic              cpu_wr_en,
  input  logic [PROG_W-1:0] cpu_wr_data,
  output logic [PROG_W-1:0] cpu_rd_data,
  output logic              boot_prog_en,
  output logic [PROG_W-2:0] boot_src
);
  localparam int              SRC_W      = PROG_W - 1;
  localparam logic [IR_W-1:0] IR_BYPASS  = '1;
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};

  // ---------------- resets ----------------
  logic tck_rst_n, sys_rst_n;

  prog_tap_rst_sync #(.STAGES(SYNC_STAGES)) i_tck_rst (
    .clk(tck), .arst_n(por_n), .rst_n(tck_rst_n));
  prog_tap_rst_sync #(.STAGES(SYNC_STAGES)) i_sys_rst (
    .clk(sys_clk), .arst_n(por_n), .rst_n(sys_rst_n));

  // ---------------- controller ----------------
  tap_state_e state;

  prog_tap_fsm i_fsm (.tck(tck), .rst_n(tck_rst_n), .tms(tms), .state(state));

  logic in_reset, cap_ir, shift_ir, upd_ir, cap_dr, shift_dr, upd_dr;
  assign in_reset = (state == TS_RESET);
  assign cap_ir   = (state == TS_CAP_IR);
  assign shift_ir = (state == TS_SHIFT_IR);
  assign upd_ir   = (state == TS_UPD_IR);
  assign cap_dr   = (state == TS_CAP_DR);
  assign shift_dr = (state == TS_SHIFT_DR);
  assign upd_dr   = (state == TS_UPD_DR);

  // ---------------- instruction register ----------------
  logic [IR_W-1:0] ir_sh_q, ir_sh_d, ir_q;
  logic            ir_sh_en;

  always_comb begin
    ir_sh_en = cap_ir | shift_ir;
    ir_sh_d  = cap_ir ? IR_CAPTURE : {tdi, ir_sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n)    ir_sh_q <= IR_CAPTURE;
    else if (ir_sh_en) ir_sh_q <= ir_sh_d;
  end

  always_ff @(negedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n)    ir_q <= IR_BYPASS;
    else if (in_reset) ir_q <= IR_BYPASS;
    else if (upd_ir)   ir_q <= ir_sh_q;
  end

  logic prog_sel;
  assign prog_sel = (ir_q == PROG_OP);

  // ---------------- data paths ----------------
  logic [PROG_W-1:0] prog_tck;
  logic [PROG_W-1:0] dr_sh_q, dr_sh_d;
  logic              dr_sh_en;
  logic              byp_q, byp_d, byp_en;

  always_comb begin
    dr_sh_en = prog_sel & (cap_dr | shift_dr);
    dr_sh_d  = cap_dr ? prog_tck : {tdi, dr_sh_q[PROG_W-1:1]};
    byp_en   = ~prog_sel & (cap_dr | shift_dr);
    byp_d    = cap_dr ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n)    dr_sh_q <= '0;
    else if (dr_sh_en) dr_sh_q <= dr_sh_d;
  end

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n)  byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // update stage on the falling edge: held value plus a toggle event
  logic [PROG_W-1:0] upd_data;
  logic              upd_tgl;
  logic              upd_en;
  assign upd_en = upd_dr & prog_sel;

  always_ff @(negedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      upd_data <= '0;
      upd_tgl  <= 1'b0;
    end else if (upd_en) begin
      upd_data <= dr_sh_q;
      upd_tgl  <= ~upd_tgl;
    end
  end

  // ---------------- serial output ----------------
  logic tdo_q, tdo_d, tdo_en_q, tdo_en_d;

  always_comb begin
    tdo_en_d = shift_ir | shift_dr;
    if (shift_ir)      tdo_d = ir_sh_q[0];
    else if (prog_sel) tdo_d = dr_sh_q[0];
    else               tdo_d = byp_q;
  end

  always_ff @(negedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= tdo_d;
      tdo_en_q <= tdo_en_d;
    end
  end

  assign tdo    = tdo_en_q & tdo_q;
  assign tdo_en = tdo_en_q;

  // ---------------- crossing into the system clock ----------------
  logic tlr_sys, upd_tgl_sys, upd_tgl_prev, upd_pulse;

  prog_tap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_tlr_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(in_reset), .q(tlr_sys));
  prog_tap_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_upd_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(upd_tgl), .q(upd_tgl_sys));

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) upd_tgl_prev <= 1'b0;
    else            upd_tgl_prev <= upd_tgl_sys;
  end
  assign upd_pulse = upd_tgl_sys ^ upd_tgl_prev;

  // ---------------- programming register ----------------
  logic [PROG_W-1:0] prog_q, prog_d;
  logic              prog_en;

  always_comb begin
    prog_en = tlr_sys | upd_pulse | cpu_wr_en;
    if (tlr_sys)        prog_d = '0;
    else if (upd_pulse) prog_d = upd_data;
    else                prog_d = cpu_wr_data;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   prog_q <= '0;
    else if (prog_en) prog_q <= prog_d;
  end

  prog_tap_sync #(.W(PROG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_cap_sync (
    .clk(tck), .rst_n(tck_rst_n), .d(prog_q), .q(prog_tck));

  assign cpu_rd_data  = prog_q;
  assign boot_prog_en = prog_q[0];
  assign boot_src     = prog_q[0] ? prog_q[PROG_W-1:1] : {SRC_W{1'b0}};
endmodule

// File: rtl/prog_tap_chk.sv
`timescale 1ns/1ps
module prog_tap_chk
  import prog_tap_pkg::*;
#(
  parameter int IR_W   = 3,
  parameter int PROG_W = 3
) (
  input logic              tck,
  input logic              sys_clk,
  input logic              tck_rst_n,
  input logic              sys_rst_n,
  input logic              tms,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir_q,
  input logic              tdo_en,
  input logic              tlr_sys,
  input logic              upd_pulse,
  input logic [PROG_W-1:0] upd_data,
  input logic              cpu_wr_en,
  input logic [PROG_W-1:0] cpu_wr_data,
  input logic [PROG_W-1:0] cpu_rd_data
);
  AST_TMS_FIVE_RESET: assert property (@(posedge tck) disable iff (!tck_rst_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> state == TS_RESET); // R1

  AST_RESET_SELECTS_BYPASS: assert property (@(posedge tck) disable iff (!tck_rst_n)
    ($past(state) == TS_RESET) |-> ir_q == {IR_W{1'b1}}); // R3

  AST_TDO_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!tck_rst_n)
    tdo_en |-> (state == TS_SHIFT_IR || state == TS_SHIFT_DR)); // R10

  AST_RESET_CLEARS_REG: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    tlr_sys |=> cpu_rd_data == '0); // R9

  AST_SERIAL_WINS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (upd_pulse && !tlr_sys) |=> cpu_rd_data == $past(upd_data)); // R8

  AST_CPU_WRITE_LANDS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (cpu_wr_en && !upd_pulse && !tlr_sys) |=> cpu_rd_data == $past(cpu_wr_data)); // R7

  AST_REG_HOLDS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (!cpu_wr_en && !upd_pulse && !tlr_sys) |=> $stable(cpu_rd_data)); // R7
endmodule

bind prog_tap_top prog_tap_chk #(.IR_W(IR_W), .PROG_W(PROG_W)) i_chk (
  .tck(tck), .sys_clk(sys_clk), .tck_rst_n(tck_rst_n), .sys_rst_n(sys_rst_n),
  .tms(tms), .state(state), .ir_q(ir_q), .tdo_en(tdo_en), .tlr_sys(tlr_sys),
  .upd_pulse(upd_pulse), .upd_data(upd_data), .cpu_wr_en(cpu_wr_en),
  .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data));

// File: tb/test_prog_tap_top.sv
`timescale 1ns/1ps
module test_prog_tap_top;
  logic       por_n, tck, tms, tdi, tdo, tdo_en, sys_clk, cpu_wr_en;
  logic [2:0] cpu_wr_data, cpu_rd_data;
  logic       boot_prog_en;
  logic [1:0] boot_src;
  int         n_vec, n_bad;
  logic       done, mon_en, saw_serial;

  prog_tap_top i_prog_tap_top (
    .por_n(por_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .sys_clk(sys_clk), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .boot_prog_en(boot_prog_en), .boot_src(boot_src));

  initial sys_clk = 1'b0;
  always #2 sys_clk = ~sys_clk;

  always @(negedge sys_clk)
    if (mon_en && cpu_wr_en && cpu_rd_data == 3'b101) saw_serial = 1'b1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one TCK period of 40 ns; TDO sampled late in the low phase
  task automatic step(input logic m, input logic d, output logic o, output logic e);
    tms = m; tdi = d;
    #10; o = tdo; e = tdo_en;
    tck = 1'b1; #20;
    tck = 1'b0; #10;
  endtask

  task automatic idle(input int n);
    logic o, e;
    repeat (n) step(1'b0, 1'b0, o, e);
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap, output logic en_all);
    logic o, e;
    en_all = 1'b1;
    step(1'b1, 1'b0, o, e); step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e); step(1'b0, 1'b0, o, e);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, e);
      cap[i] = o; en_all &= e;
    end
    step(1'b1, 1'b0, o, e); step(1'b0, 1'b0, o, e);
  endtask

  task automatic dr_scan(input int n, input logic [7:0] din, output logic [7:0] dout);
    logic o, e;
    dout = '0;
    step(1'b1, 1'b0, o, e);
    step(1'b0, 1'b0, o, e); step(1'b0, 1'b0, o, e);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, e);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o, e); step(1'b0, 1'b0, o, e);
  endtask

  task automatic cpu_write(input logic [2:0] v);
    @(negedge sys_clk); cpu_wr_en = 1'b1; cpu_wr_data = v;
    @(negedge sys_clk); cpu_wr_en = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] cap, prev;
    logic [7:0] dout;
    logic       en_all, o, e;
    n_vec = 0; n_bad = 0; mon_en = 1'b0; saw_serial = 1'b0;
    por_n = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b0;
    cpu_wr_en = 1'b0; cpu_wr_data = '0;
    #21;
    chk("R9 reset value", {5'b0, cpu_rd_data}, 8'h0);
    chk("R6 reset enable", {7'b0, boot_prog_en}, 8'h0);
    chk("R10 reset tdo_en", {7'b0, tdo_en}, 8'h0);
    por_n = 1'b1;
    repeat (6) step(1'b1, 1'b0, o, e);
    idle(1);

    // R2: capture pattern and instruction load
    ir_scan(3'b100, cap, en_all);
    chk("R2 capture-IR pattern", {5'b0, cap}, 8'h01);
    chk("R10 tdo_en during shift", {7'b0, en_all}, 8'h1);
    chk("R10 tdo_en idle", {7'b0, tdo_en}, 8'h0);

    // R4/R6/R7: every value written serially, read back serially and by CPU
    prev = 3'b000;
    for (int v = 0; v < 8; v++) begin
      dr_scan(3, 8'(v), dout);
      #40;
      chk("R4 serial readback (R3 instruction kept)", dout, {5'b0, prev});
      chk("R7 cpu sees serial write", {5'b0, cpu_rd_data}, 8'(v));
      chk("R6 enable bit", {7'b0, boot_prog_en}, {7'b0, 1'(v & 1)});
      chk("R6 gated source", {6'b0, boot_src}, (v & 1) ? 8'(v >> 1) : 8'h0);
      prev = 3'(v);
    end

    // R7/R4: CPU writes visible on the serial side
    for (int v = 0; v < 8; v++) begin
      cpu_write(3'(v));
      chk("R7 cpu write", {5'b0, cpu_rd_data}, 8'(v));
      idle(2);
      dr_scan(3, 8'(v), dout);
      chk("R4 capture of cpu value", dout, 8'(v));
    end

    // R5: every other code is bypass and leaves the register alone
    for (int c = 0; c < 8; c++) begin
      if (c != 4) begin
        logic [7:0] din;
        din = 8'(4'hA ^ c);
        cpu_write(3'b110);
        ir_scan(3'(c), cap, en_all);
        dr_scan(4, din, dout);
        #40;
        chk("R5 bypass path", {4'b0, dout[3:0]}, {4'b0, din[2:0], 1'b0});
        chk("R5 register untouched", {5'b0, cpu_rd_data}, 8'h06);
      end
    end

    // R1/R9/R3: five TMS highs clear the register and select bypass
    ir_scan(3'b100, cap, en_all);
    dr_scan(3, 8'h03, dout);
    #40;
    chk("R4 write before reset", {5'b0, cpu_rd_data}, 8'h03);
    repeat (5) step(1'b1, 1'b0, o, e);
    #40;
    chk("R1 R9 register cleared by five TMS highs", {5'b0, cpu_rd_data}, 8'h0);
    idle(1);
    dr_scan(4, 8'h05, dout);
    #40;
    chk("R3 bypass after reset state", {4'b0, dout[3:0]}, 8'h0A);
    chk("R3 register unchanged", {5'b0, cpu_rd_data}, 8'h0);

    // R8: serial update lands while the CPU writes every cycle
    ir_scan(3'b100, cap, en_all);
    @(negedge sys_clk); cpu_wr_en = 1'b1; cpu_wr_data = 3'b010;
    mon_en = 1'b1;
    dr_scan(3, 8'h05, dout);
    #40;
    mon_en = 1'b0;
    @(negedge sys_clk); cpu_wr_en = 1'b0;
    @(negedge sys_clk);
    chk("R8 serial value won the shared cycle", {7'b0, saw_serial}, 8'h1);
    chk("R8 later cpu writes resume", {5'b0, cpu_rd_data}, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule